// File: doc/BRIEF.md
# Debounced Up/Down Gray Counter

This block keeps a small count that two push-buttons move: one button steps it up, the other steps it down. Every raw button line is first brought into the clock domain by a two-stage synchroniser. A level is then only taken as real once it has held steady for a programmable number of clock cycles, and a one-cycle pulse is produced on each accepted press. Contact bounce therefore never counts as extra presses, and a button held down steps the count exactly once.

The count is stored in binary in a register and wraps modulo 2^WIDTH in both directions. A purely combinational stage turns it into Gray code for the LED outputs, so neighbouring count values differ on exactly one LED. An active-high reset clears the count and blanks the LEDs for as long as it is held.

Top module: `gray_updown_counter`

## Requirements
- R1: While rst_i is high, led_o is all zeros, and after rst_i falls with both buttons low, led_o stays all zeros (count is zero).
- R2: A clean press of btn_up_i (held at least DEBOUNCE_CYCLES plus a few cycles, then released) increases the count by exactly one.
- R3: A clean press of btn_down_i decreases the count by exactly one.
- R4: The count wraps: one step up from 2^WIDTH-1 gives 0, and one step down from 0 gives 2^WIDTH-1 (led_o = 4'b1000 for WIDTH 4).
- R5: led_o carries the Gray code of the count, led_o = count ^ (count >> 1), bit i of the result on led_o[i].
- R6: A raw button level that lasts fewer than DEBOUNCE_CYCLES cycles is ignored: such glitches alone leave the count unchanged.
- R7: Holding a button down for many debounce periods steps the count only once; there is no auto-repeat.
- R8: When both buttons are accepted as pressed in the same clock cycle, the count does not change.
- R9: Bounce before and after a genuine press still yields exactly one step per press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous active-high reset; clears the count and blanks the LEDs |
| btn_up_i | input | 1 | Raw, asynchronous increment button (high = pressed) |
| btn_down_i | input | 1 | Raw, asynchronous decrement button (high = pressed) |
| led_o | output | WIDTH | Gray-coded count, one bit per LED |

## Verification
The assertions assume the raw button lines behave like real mechanical contacts: any level that the debouncer accepts is separated from the next accepted change by at least a full debounce window, so accepted pulses are always isolated single cycles. The stimulus respects this by building every press from bursts of bounce that are each shorter than the debounce window, followed by a steady hold and a steady release that are each longer than it, and by holding the buttons low around reset release. Simultaneous presses are driven edge-aligned on both lines so that both pulses land in the same cycle.

// File: rtl/gray_ctr_pkg.sv
package gray_ctr_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    function automatic step_e step_sel(input logic up, input logic down);
        step_e s;
        s = STEP_HOLD;
        if (up && !down) begin
            s = STEP_UP;
        end else if (down && !up) begin
            s = STEP_DOWN;
        end
        return s;
    endfunction

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
    parameter int unsigned DEBOUNCE_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_i,
    output logic press_o
);
    localparam int unsigned CW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

    typedef struct packed {
        logic          meta;
        logic          synced;
        logic          level;
        logic [CW-1:0] wait_cnt;
        logic          press;
    } cond_t;

    cond_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = raw_i;
        st_d.synced = st_q.meta;
        st_d.press  = 1'b0;
        if (st_q.synced != st_q.level) begin
            if (st_q.wait_cnt == LAST) begin
                st_d.level    = st_q.synced;
                st_d.wait_cnt = '0;
                st_d.press    = st_q.synced;
            end else begin
                st_d.wait_cnt = st_q.wait_cnt + 1'b1;
            end
        end else begin
            st_d.wait_cnt = '0;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign press_o = st_q.press;

    AST_ACCEPT_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.level != $past(st_q.level)) |-> ($past(st_q.wait_cnt) == LAST)); // R6
    AST_PRESS_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.press |=> !st_q.press); // R7
    AST_PRESS_ON_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.press |-> (st_q.level && !$past(st_q.level))); // R9

endmodule

// File: rtl/updown_core.sv
module updown_core
    import gray_ctr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             up_i,
    input  logic             down_i,
    output logic [WIDTH-1:0] count_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
    localparam logic [WIDTH-1:0] TOP = '1;

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } core_t;

    core_t st_d, st_q;
    step_e step;

    always_comb begin
        st_d = st_q;
        step = step_sel(up_i, down_i);
        unique case (step)
            STEP_UP:   st_d.count = st_q.count + ONE;
            STEP_DOWN: st_d.count = st_q.count - ONE;
            default:   st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

    AST_STEP_UP: assert property (@(posedge clk_i) disable iff (rst_i)
        (up_i && !down_i) |=> (st_q.count == $past(st_q.count) + ONE)); // R2
    AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
        (down_i && !up_i) |=> (st_q.count == $past(st_q.count) - ONE)); // R3
    AST_WRAP_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (up_i && !down_i && st_q.count == TOP) |=> (st_q.count == '0)); // R4
    AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (up_i && down_i) |=> $stable(st_q.count)); // R8

endmodule

// File: rtl/bin2gray.sv
module bin2gray #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] bin_i,
    output logic [WIDTH-1:0] gray_o
);
    generate
        for (genvar i = 0; i < WIDTH - 1; i++) begin : g_bit
            assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
        end
    endgenerate
    assign gray_o[WIDTH-1] = bin_i[WIDTH-1];
endmodule

// File: rtl/gray_updown_counter.sv
module gray_updown_counter #(
    parameter int unsigned WIDTH           = 4,
    parameter int unsigned DEBOUNCE_CYCLES = 1250000
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             btn_up_i,
    input  logic             btn_down_i,
    output logic [WIDTH-1:0] led_o
);
    localparam int unsigned NUM_BTN = 2;

    logic [NUM_BTN-1:0] raw;
    logic [NUM_BTN-1:0] press;
    logic [WIDTH-1:0]   count;
    logic [WIDTH-1:0]   gray;

    assign raw = {btn_down_i, btn_up_i};

    generate
        for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
            btn_conditioner #(
                .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
            ) cond_i (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .raw_i  (raw[b]),
                .press_o(press[b])
            );
        end
    endgenerate

    updown_core #(
        .WIDTH(WIDTH)
    ) core_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .up_i   (press[0]),
        .down_i (press[1]),
        .count_o(count)
    );

    bin2gray #(
        .WIDTH(WIDTH)
    ) conv_i (
        .bin_i (count),
        .gray_o(gray)
    );

    assign led_o = rst_i ? '0 : gray;

    AST_GRAY_ONE_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(led_o ^ $past(led_o)) <= 1); // R5

endmodule

// File: tb/gray_updown_counter_tb_top.sv
module gray_updown_counter_tb_top;
    localparam int W   = 4;
    localparam int DBC = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         up;
    logic         dn;
    logic [W-1:0] led;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    int unsigned exp_cnt = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    gray_updown_counter #(.WIDTH(W), .DEBOUNCE_CYCLES(DBC)) dut_i (
        .clk_i(clk), .rst_i(rst), .btn_up_i(up), .btn_down_i(dn), .led_o(led)
    );

    function automatic logic [W-1:0] to_gray(input int unsigned v);
        logic [W-1:0] b;
        b = W'(v);
        return b ^ (b >> 1);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W-1:0] exp);
        @(negedge clk);
        checks++;
        if (led !== exp) begin
            fails++;
            $display("FAIL %s: led=%b expected=%b", req, led, exp);
        end
    endtask

    // which: 0 up, 1 down, 2 both
    task automatic drive(input int which, input logic v);
        if (which != 1) up = v;
        if (which != 0) dn = v;
    endtask

    task automatic press(input int which, input int bounces, input int hold);
        for (int i = 0; i < bounces; i++) begin
            drive(which, 1'b1); cyc(1 + $urandom_range(DBC/2));
            drive(which, 1'b0); cyc(1 + $urandom_range(DBC/2));
        end
        drive(which, 1'b1); cyc(DBC + 6 + hold);
        for (int i = 0; i < bounces; i++) begin
            drive(which, 1'b0); cyc(1 + $urandom_range(DBC/2));
            drive(which, 1'b1); cyc(1 + $urandom_range(DBC/2));
        end
        drive(which, 1'b0); cyc(DBC + 6);
        if (which == 0) exp_cnt = (exp_cnt + 1) % (1 << W);
        if (which == 1) exp_cnt = (exp_cnt + (1 << W) - 1) % (1 << W);
    endtask

    task automatic glitch(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            drive(which, 1'b1); cyc(1 + $urandom_range(DBC - 4));
            drive(which, 1'b0); cyc(1 + $urandom_range(DBC - 4));
        end
        cyc(DBC + 6);
    endtask

    initial begin
        cyc(150000);
        checks++;
        fails++;
        $display("FAIL watchdog: led=%b expected=finished run", led);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; up = 1'b0; dn = 1'b0;
        cyc(3);
        check("R1 in reset", '0);
        up = 1'b1; cyc(DBC + 6);
        check("R1 reset with button held", '0);
        up = 1'b0; cyc(4);
        rst = 1'b0; cyc(DBC + 6);
        check("R1 after reset", '0);

        press(1, 0, 0);
        check("R4 wrap below zero", to_gray(exp_cnt));
        check("R4 encoding 15", 4'b1000);
        press(0, 0, 0);
        check("R4 wrap above top", to_gray(exp_cnt));
        press(0, 3, 0);
        check("R2 up with bounce", to_gray(exp_cnt));
        press(0, 0, 0);
        check("R5 gray of 2", 4'b0011);
        press(1, 2, 0);
        check("R3 down with bounce", to_gray(exp_cnt));
        press(0, 0, 5 * DBC);
        check("R7 long hold single step", to_gray(exp_cnt));
        glitch(0, 6);
        check("R6 up glitches ignored", to_gray(exp_cnt));
        glitch(1, 6);
        check("R6 down glitches ignored", to_gray(exp_cnt));
        press(2, 0, 0);
        check("R8 both together hold", to_gray(exp_cnt));

        for (int k = 0; k < 40; k++) begin
            int op;
            op = $urandom_range(4);
            if (op <= 1) begin
                press(op, $urandom_range(3), $urandom_range(DBC));
                check(op == 0 ? "R9 random up" : "R9 random down", to_gray(exp_cnt));
            end else if (op == 2) begin
                press(1, $urandom_range(2), 0);
                check("R3 random down", to_gray(exp_cnt));
            end else if (op == 3) begin
                press(2, 0, $urandom_range(DBC));
                check("R8 random both", to_gray(exp_cnt));
            end else begin
                glitch($urandom_range(1), 1 + $urandom_range(3));
                check("R6 random glitch", to_gray(exp_cnt));
            end
        end

        rst = 1'b1; cyc(2);
        check("R1 late reset blank", '0);
        rst = 1'b0; cyc(4);
        check("R1 late reset cleared", '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule